// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-cycle 32-bit RISC core and decides, every clock, which address is fetched next. It looks at the instruction word currently being executed and at the equality flag produced by the ALU. From these it picks one of three candidates: the sequential address, a conditional branch target, or a pseudo-absolute jump target.

The sequential address is always the current PC plus four. Branch targets are computed relative to that incremented address. The 16-bit immediate counts whole instructions, so it is sign-extended and then scaled by four. A jump target keeps the upper nibble of PC+4 and replaces everything below it with the 26-bit instruction field shifted left by two.

A synchronous reset loads a parameterised reset vector. When the advance enable is low, the PC freezes so the core can stall. The current PC and PC+4 are both available as outputs.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` is loaded with the parameter `RESET_VEC` (default 0x0040_0000). This load takes precedence over `step_en`.
- R2: When `rst` is low and `step_en` is low, `pc` keeps its value across the clock edge, whatever the instruction and flag are.
- R3: `pc_plus4` always equals `pc` + 4, modulo 2^32.
- R4: For opcode bits [31:26] = 6'b000010 (jump), the next `pc` is {pc_plus4[31:28], instr[25:0], 2'b00}. For example, a field of 10000 jumps to byte address 40000.
- R5: For opcode 6'b000100 (branch if equal) with `eq_flag` = 1, the next `pc` is `pc_plus4` + (sign-extended instr[15:0] × 4). For example, an offset of 12 taken from PC+4 = 0x0040_0010 lands on 0x0040_0040.
- R6: For opcode 6'b000101 (branch if not equal) with `eq_flag` = 0, the next `pc` is `pc_plus4` + (sign-extended instr[15:0] × 4).
- R7: A branch whose condition fails, and every opcode other than the three above, loads `pc_plus4` into `pc`.
- R8: Branch offsets are signed. Bit 15 set moves the PC backwards; for example, offset −6 targets 24 bytes below `pc_plus4`. An offset of 0x8000 reaches 131072 bytes below `pc_plus4`.
- R9: Bits [1:0] of `pc` are always 00 after reset.
- R10: The upper nibble of a jump target is taken from PC+4, not from PC. A jump at 0x0FFF_FFFC with a field of 0 therefore lands on 0x1000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance enable; low stalls the PC |
| instr | input | 32 | Instruction word at the current PC |
| eq_flag | input | 1 | ALU equality result (1 = operands equal) |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus four |

## Verification
Several properties are checked on every clock edge: the increment relation, the stall hold, word alignment, and the next-PC rule for each opcode class. For jumps this includes that the upper nibble comes from PC+4. Only the bench's scenarios can show the reset-vector value, including a reset raised in mid-run while stalled. The same holds for the specific worked encodings: the jump to 40000, the offset-12 branch and the −6 backward branch. The nibble carry at 0x0FFF_FFFC and the extreme offsets also come from the bench, which sweeps every opcode against both flag values and a set of boundary immediates.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned OPC_W      = 6;
    localparam int unsigned JFIELD_W   = 26;
    localparam int unsigned IMM_W      = 16;
    localparam int unsigned ALIGN_W    = 2;
    localparam int unsigned REGION_W   = WORD_W - JFIELD_W - ALIGN_W;
    localparam int unsigned STEP_BYTES = 4;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'b000101;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        NXT_SEQ  = 2'd0,
        NXT_BR   = 2'd1,
        NXT_JUMP = 2'd2
    } nxt_sel_e;

    typedef struct packed {
        logic [OPC_W-1:0]    opc;
        logic [JFIELD_W-1:0] body;
    } instr_s;

    function automatic word_t scaled_offset(input logic [IMM_W-1:0] imm);
        return {{(WORD_W-IMM_W-ALIGN_W){imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    endfunction

    function automatic word_t region_target(input word_t seq, input logic [JFIELD_W-1:0] fld);
        return {seq[WORD_W-1 -: REGION_W], fld, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic             eq_flag,
    output nxt_sel_e         sel
);
    logic is_beq;
    logic is_bne;
    logic taken;

    always_comb begin
        is_beq = (opc == OPC_BEQ);
        is_bne = (opc == OPC_BNE);
        taken  = (is_beq && eq_flag) || (is_bne && !eq_flag);
        if (opc == OPC_JUMP) begin
            sel = NXT_JUMP;
        end else if (taken) begin
            sel = NXT_BR;
        end else begin
            sel = NXT_SEQ;
        end
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  word_t  seq_addr,
    input  instr_s ins,
    output word_t  br_addr,
    output word_t  jmp_addr
);
    word_t off;

    always_comb begin
        off      = scaled_offset(ins.body[IMM_W-1:0]);
        br_addr  = seq_addr + off;
        jmp_addr = region_target(seq_addr, ins.body);
    end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
    import npc_pkg::*;
#(
    parameter word_t RESET_VEC = 32'h0040_0000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  word_t d,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VEC;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step_en,
    input  logic [31:0] instr,
    input  logic        eq_flag,
    output logic [31:0] pc,
    output logic [31:0] pc_plus4
);
    instr_s   ins;
    nxt_sel_e sel;
    word_t    br_addr;
    word_t    jmp_addr;
    word_t    nxt;

    assign ins      = instr_s'(instr);
    assign pc_plus4 = pc + word_t'(STEP_BYTES);

    npc_select i_select (
        .opc     (ins.opc),
        .eq_flag (eq_flag),
        .sel     (sel)
    );

    npc_targets i_targets (
        .seq_addr (pc_plus4),
        .ins      (ins),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr)
    );

    always_comb begin
        unique case (sel)
            NXT_BR:   nxt = br_addr;
            NXT_JUMP: nxt = jmp_addr;
            default:  nxt = pc_plus4;
        endcase
    end

    npc_pc_reg #(.RESET_VEC(RESET_VEC)) i_pc_reg (
        .clk (clk),
        .rst (rst),
        .en  (step_en),
        .d   (nxt),
        .q   (pc)
    );
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        step_en,
    input logic [31:0] instr,
    input logic        eq_flag,
    input logic [31:0] pc,
    input logic [31:0] pc_plus4
);
    logic [5:0]  opc;
    logic [31:0] off;
    logic        is_j;
    logic        is_beq;
    logic        is_bne;

    assign opc    = instr[31:26];
    assign off    = {{14{instr[15]}}, instr[15:0], 2'b00};
    assign is_j   = (opc == 6'b000010);
    assign is_beq = (opc == 6'b000100);
    assign is_bne = (opc == 6'b000101);

    // R3
    p_increment_r3: assert property (@(posedge clk) disable iff (rst)
        pc_plus4 == pc + 32'd4);

    // R2
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pc));

    // R9
    p_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    // R4 and R10
    p_jump_target_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && is_j) |=>
            (pc[27:2] == $past(instr[25:0])) && (pc[31:28] == $past(pc_plus4[31:28])));

    // R5 and R8
    p_beq_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (step_en && is_beq && eq_flag) |=> pc == $past(pc_plus4 + off));

    // R6
    p_bne_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (step_en && is_bne && !eq_flag) |=> pc == $past(pc_plus4 + off));

    // R7
    p_sequential_r7: assert property (@(posedge clk) disable iff (rst)
        (step_en && !is_j && !(is_beq && eq_flag) && !(is_bne && !eq_flag))
            |=> pc == $past(pc_plus4));
endmodule

bind next_pc_unit next_pc_unit_chk i_next_pc_unit_chk (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .instr    (instr),
    .eq_flag  (eq_flag),
    .pc       (pc),
    .pc_plus4 (pc_plus4)
);

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;
    localparam logic [31:0] RV = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic [31:0] instr = 32'd0;
    logic        eq_flag = 1'b0;
    logic [31:0] pc;
    logic [31:0] pc_plus4;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] model_pc;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    next_pc_unit #(.RESET_VEC(RV)) i_next_pc_unit (
        .clk(clk), .rst(rst), .step_en(step_en), .instr(instr),
        .eq_flag(eq_flag), .pc(pc), .pc_plus4(pc_plus4)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] predict(input logic [31:0] cur, input logic [31:0] ins,
                                            input logic eq, input logic en);
        logic [31:0] seq;
        logic [31:0] offs;
        seq  = cur + 32'd4;
        offs = 32'(signed'(ins[15:0])) * 32'sd4;
        if (!en)                                 return cur;
        if (ins[31:26] == 6'd2)                  return {seq[31:28], ins[25:0], 2'b00};
        if (ins[31:26] == 6'd4 && eq)            return seq + offs;
        if (ins[31:26] == 6'd5 && !eq)           return seq + offs;
        return seq;
    endfunction

    // one clock: drive, clock, then compare against the model
    task automatic step(input string req, input logic [31:0] ins, input logic eq, input logic en);
        instr   = ins;
        eq_flag = eq;
        step_en = en;
        check("R3", pc_plus4, model_pc + 32'd4);
        model_pc = predict(model_pc, ins, eq, en);
        @(posedge clk);
        #1;
        check(req, pc, model_pc);
        if (pc[1:0] != 2'b00) check("R9", {30'd0, pc[1:0]}, 32'd0);
        @(negedge clk);
    endtask

    function automatic logic [31:0] jmp(input logic [25:0] f);
        return {6'b000010, f};
    endfunction

    function automatic logic [31:0] br(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd9, 5'd3, imm};
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] imms [7];
        imms = '{16'h0000, 16'h0001, 16'hFFFF, 16'h000C, 16'hFFFA, 16'h7FFF, 16'h8000};

        repeat (3) @(posedge clk);
        #1;
        check("R1 reset vector", pc, RV);
        model_pc = RV;
        @(negedge clk);
        rst = 1'b0;

        // R4: jump to byte address 40000 via field 10000
        step("R4 jump 40000", jmp(26'd10000), 1'b0, 1'b1);
        check("R4 jump 40000", pc, 32'd40000);

        // R5: branch from PC+4 = 0x00400010 to 0x00400040 (offset 12)
        step("R4 jump setup", jmp(26'h0100003), 1'b0, 1'b1);
        check("R4 setup", pc, 32'h0040_000C);
        step("R5 beq offset 12", br(6'd4, 16'd12), 1'b1, 1'b1);
        check("R5 beq offset 12", pc, 32'h0040_0040);

        // R8: offset -6 lands 24 bytes below PC+4
        step("R8 bne -6", br(6'd5, 16'hFFFA), 1'b0, 1'b1);
        check("R8 bne -6", pc, 32'h0040_0044 - 32'd24);

        // R7: untaken branches
        step("R7 beq not taken", br(6'd4, 16'd100), 1'b0, 1'b1);
        step("R7 bne not taken", br(6'd5, 16'd100), 1'b1, 1'b1);

        // R2: stall holds even on a jump
        step("R2 stall", jmp(26'h3FFFFFF), 1'b1, 1'b0);
        step("R2 stall branch", br(6'd4, 16'd5), 1'b1, 1'b0);

        // R10: nibble carried from PC+4
        step("R4 to 0x0FFFFFFC", jmp(26'h3FFFFFF), 1'b0, 1'b1);
        check("R10 setup", pc, 32'h0FFF_FFFC);
        step("R10 nibble from PC+4", jmp(26'd0), 1'b0, 1'b1);
        check("R10 nibble from PC+4", pc, 32'h1000_0000);

        // sweep: every opcode, both flag values, boundary immediates
        for (int op = 0; op < 64; op++) begin
            for (int e = 0; e < 2; e++) begin
                for (int k = 0; k < 7; k++) begin
                    logic [31:0] w;
                    w = {6'(op), 10'(op * 37 + k), imms[k]};
                    if (op == 2)                    step("R4 sweep", w, e[0], 1'b1);
                    else if (op == 4 && e == 1)     step("R5 sweep", w, e[0], 1'b1);
                    else if (op == 5 && e == 0)     step("R6 sweep", w, e[0], 1'b1);
                    else                            step("R7 sweep", w, e[0], 1'b1);
                end
            end
            step("R2 sweep stall", {6'(op), 26'h155AA}, op[0], 1'b0);
        end

        // R8: largest backward reach
        step("R8 offset 0x8000", br(6'd4, 16'h8000), 1'b1, 1'b1);

        // R1: reset in mid-run while stalled
        rst = 1'b1;
        step_en = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", pc, RV);
        @(negedge clk);
        rst = 1'b0;
        model_pc = RV;
        step("R7 after reset", 32'h0000_0020, 1'b0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule